// File: doc/BRIEF.md
# Packet-Counting Transmit FIFO Controller

This block is the per-port transmit store between a host write bus and a MAC transmitter. The host writes 32-bit words and marks the last word of each packet with an end flag and a byte-valid field. The block keeps the words in order and counts the complete packets it holds. It tells the host when it may write, and it tells the MAC side when a packet may be pulled out.

No more than two complete packets are held at once, however much word space is free. The MAC side may start on the head packet as soon as its end word is stored. It may also start earlier, once the number of stored words reaches a programmable threshold. A high threshold lowers the risk of running dry in the middle of a packet. A low threshold gives earlier starts on long packets. If the MAC side asks for a word of a started packet and no word is stored and the packet's end has not arrived, the block flags an underflow and drops the rest of that packet.

Top module: `pkt_tx_fifo`

## Requirements
- R1: After synchronous reset, the outputs are `tx_ready`=1, `tx_go`=0, `pkt_count`=0, `ovf_err`=0, `underflow`=0 and `mac_valid`=0.
- R2: `pkt_count` goes up on the clock edge that accepts a write with `wr_eop`=1. It goes down on the edge where the MAC side reads the last word of the head packet.
- R3: `tx_ready` goes low on the edge that brings `pkt_count` to 2 or the word fill to DEPTH. It is high otherwise.
- R4: A write presented while `tx_ready` is low is not stored and sets `ovf_err`. `ovf_err` then stays set until reset.
- R5: `tx_go` rises on the edge that accepts the end word of the head packet.
- R6: With `cfg_thresh` nonzero, `tx_go` rises on the edge where the stored word count reaches `cfg_thresh`, even before an end word has arrived. The value 0 turns the threshold start off.
- R7: A `mac_rd` taken while `tx_go` is high and words are stored removes the oldest word. That word appears on `mac_data`/`mac_be`/`mac_eop` with `mac_valid`=1 one cycle later. `mac_be` bit i marks byte i (bits 8i+7:8i) as valid, and `mac_eop`=1 marks the last word.
- R8: `mac_rd` while `tx_go` is low removes nothing, and `mac_valid` stays 0.
- R9: `tx_go` falls on the edge that reads the head packet's end word. If another complete packet is stored, `tx_go` stays high instead.
- R10: `mac_rd` while `tx_go` is high and no word is stored causes the following:
  - `underflow` pulses for one cycle and `tx_go` falls.
  - Every later write, up to and including the next end word, is discarded.
  - The discarded writes change neither `pkt_count` nor `ovf_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write word |
| wr_eop | input | 1 | Marks the last word of a packet |
| wr_be | input | 4 | Byte-valid field, meaningful on the last word |
| tx_ready | output | 1 | Host may write |
| cfg_thresh | input | 9 | Start threshold in words, 0 = off |
| mac_rd | input | 1 | MAC side takes one word |
| tx_go | output | 1 | Head packet may be sent |
| mac_valid | output | 1 | Word on mac_* is new this cycle |
| mac_data | output | 32 | Word read out |
| mac_be | output | 4 | Byte-valid of word read out |
| mac_eop | output | 1 | Word read out ends a packet |
| underflow | output | 1 | One-cycle pulse on a dry read |
| pkt_count | output | 2 | Complete packets held |
| ovf_err | output | 1 | Sticky write-while-not-ready flag |

## Verification
Suppose the end-address queue or the packet counter slips. Then `tx_go` stays high past the end of a packet or drops on the wrong word. The scoreboard sees this within one read as a missing, extra or reordered word. A wrong fill count moves the threshold start and the full point of `tx_ready` by at least one edge, and the bench samples both on the exact edge. A write stored when it should have been dropped surfaces as an extra word at the head of a later packet.

// File: rtl/ptf_pkg.sv
package ptf_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  typedef struct packed {
    logic              eop;
    logic [BE_W-1:0]   be;
    logic [DATA_W-1:0] data;
  } word_t;
endpackage

// File: rtl/ptf_ram.sv
module ptf_ram
  import ptf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  word_t mem [DEPTH];

  // one write port, one registered read port: maps onto a simple dual-port RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ptf_pkt_track.sv
module ptf_pkt_track #(
  parameter int AW       = 8,
  parameter int MAX_PKTS = 2,
  parameter int CNT_W    = 2,
  parameter int IW       = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [AW-1:0]    push_addr,
  input  logic             pop,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next,
  output logic [AW-1:0]    head_addr
);
  logic [AW-1:0] slot [MAX_PKTS];
  logic [IW-1:0] head_i, tail_i;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] x);
    return (x == IW'(MAX_PKTS - 1)) ? '0 : x + 1'b1;
  endfunction

  assign cnt_next  = cnt_q + CNT_W'(push) - CNT_W'(pop);
  assign head_addr = slot[head_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      head_i <= '0;
      tail_i <= '0;
    end else begin
      cnt_q <= cnt_next;
      if (push) tail_i <= nxt(tail_i);
      if (pop)  head_i <= nxt(head_i);
    end
  end

  // one register per resident packet, holding the address of its end word
  for (genvar i = 0; i < MAX_PKTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && tail_i == IW'(i)) slot[i] <= push_addr;
    end
  end

  // R2: never more complete packets than slots, never pop an empty queue
  a_r2_no_push_at_limit: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt_q < CNT_W'(MAX_PKTS)) || pop);
  a_r2_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    pop |-> cnt_q != '0);
  a_r2_count_quiet: assert property (@(posedge clk) disable iff (rst)
    (!push && !pop) |=> $stable(cnt_q));
endmodule

// File: rtl/ptf_start_ctl.sv
module ptf_start_ctl #(
  parameter int AW = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mac_rd,
  input  logic [AW:0] fill,
  input  logic [AW:0] fill_next,
  input  logic        cnt_nz_next,
  input  logic        eop_pop,
  input  logic [AW:0] cfg_thresh,
  output logic        started_q,
  output logic        unf_cond,
  output logic        unf_q
);
  logic thr_hit, started_d;

  assign unf_cond  = mac_rd && started_q && (fill == '0);
  assign thr_hit   = (cfg_thresh != '0) && (fill_next >= cfg_thresh);
  assign started_d = unf_cond ? 1'b0
                   : ((started_q && !eop_pop) || cnt_nz_next || thr_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      unf_q     <= 1'b0;
    end else begin
      started_q <= started_d;
      unf_q     <= unf_cond;
    end
  end

  // R10: underflow is a single-cycle pulse and always ends the start
  a_r10_unf_pulse: assert property (@(posedge clk) disable iff (rst)
    unf_q |=> !unf_q);
  a_r10_unf_stops: assert property (@(posedge clk) disable iff (rst)
    unf_q |-> !started_q);
endmodule

// File: rtl/pkt_tx_fifo.sv
module pkt_tx_fifo
  import ptf_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int MAX_PKTS = 2,
  localparam int AW      = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(MAX_PKTS + 1),
  localparam int IW      = (MAX_PKTS > 1) ? $clog2(MAX_PKTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_eop,
  input  logic [BE_W-1:0]   wr_be,
  output logic              tx_ready,
  input  logic [AW:0]       cfg_thresh,
  input  logic              mac_rd,
  output logic              tx_go,
  output logic              mac_valid,
  output logic [DATA_W-1:0] mac_data,
  output logic [BE_W-1:0]   mac_be,
  output logic              mac_eop,
  output logic              underflow,
  output logic [CNT_W-1:0]  pkt_count,
  output logic              ovf_err
);
  logic [AW-1:0]    wr_ptr, rd_ptr, head_eop;
  logic [AW:0]      fill, fill_next;
  logic [CNT_W-1:0] cnt_q, cnt_next;
  logic             ready_q, drop_q, drop_now, ovf_q, valid_q;
  logic             accept, pop, eop_pop, started, unf_cond, unf_q;
  word_t            wr_word, rd_word;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign drop_now  = drop_q || unf_cond;
  assign accept    = wr_en && ready_q && !drop_now;
  assign pop       = mac_rd && started && (fill != '0);
  assign eop_pop   = pop && (cnt_q != '0) && (rd_ptr == head_eop);
  assign fill_next = fill + (AW+1)'(accept) - (AW+1)'(pop);
  assign wr_word   = '{eop: wr_eop, be: wr_be, data: wr_data};

  ptf_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(accept), .waddr(wr_ptr), .wdata(wr_word),
    .re(pop), .raddr(rd_ptr), .rdata(rd_word)
  );

  ptf_pkt_track #(.AW(AW), .MAX_PKTS(MAX_PKTS), .CNT_W(CNT_W), .IW(IW)) u_track (
    .clk(clk), .rst(rst), .push(accept && wr_eop), .push_addr(wr_ptr),
    .pop(eop_pop), .cnt_q(cnt_q), .cnt_next(cnt_next), .head_addr(head_eop)
  );

  ptf_start_ctl #(.AW(AW)) u_start (
    .clk(clk), .rst(rst), .mac_rd(mac_rd), .fill(fill), .fill_next(fill_next),
    .cnt_nz_next(cnt_next != '0), .eop_pop(eop_pop), .cfg_thresh(cfg_thresh),
    .started_q(started), .unf_cond(unf_cond), .unf_q(unf_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      fill    <= '0;
      ready_q <= 1'b1;
      drop_q  <= 1'b0;
      ovf_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (accept) wr_ptr <= inc(wr_ptr);
      if (pop)    rd_ptr <= inc(rd_ptr);
      fill    <= fill_next;
      ready_q <= (fill_next != (AW+1)'(DEPTH)) && (cnt_next < CNT_W'(MAX_PKTS));
      valid_q <= pop;
      if (wr_en && !ready_q) ovf_q <= 1'b1;
      // discard the tail of an aborted packet up to and including its end word
      if (drop_now) drop_q <= !(wr_en && wr_eop && ready_q);
    end
  end

  assign tx_ready  = ready_q;
  assign tx_go     = started;
  assign mac_valid = valid_q;
  assign mac_data  = rd_word.data;
  assign mac_be    = rd_word.be;
  assign mac_eop   = rd_word.eop;
  assign underflow = unf_q;
  assign pkt_count = cnt_q;
  assign ovf_err   = ovf_q;

  a_r3_ready_low_at_limit: assert property (@(posedge clk) disable iff (rst)
    (pkt_count == CNT_W'(MAX_PKTS)) |-> !tx_ready);
  a_r3_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fill <= (AW+1)'(DEPTH));
  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);
  a_r7_valid_needs_go: assert property (@(posedge clk) disable iff (rst)
    mac_valid |-> $past(tx_go));
  a_r8_idle_read: assert property (@(posedge clk) disable iff (rst)
    (!tx_go && mac_rd) |=> !mac_valid);
endmodule

// File: tb/pkt_tx_fifo_test.sv
module pkt_tx_fifo_test;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 256;

  logic        clk = 1'b0;
  logic        rst, wr_en, wr_eop, mac_rd;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;
  logic [8:0]  cfg_thresh;
  logic        tx_ready, tx_go, mac_valid, mac_eop, underflow, ovf_err;
  logic [31:0] mac_data;
  logic [3:0]  mac_be;
  logic [1:0]  pkt_count;

  int n_chk = 0, n_fail = 0;
  logic [36:0] exp_q [$];

  pkt_tx_fifo #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_eop(wr_eop),
    .wr_be(wr_be), .tx_ready(tx_ready), .cfg_thresh(cfg_thresh), .mac_rd(mac_rd),
    .tx_go(tx_go), .mac_valid(mac_valid), .mac_data(mac_data), .mac_be(mac_be),
    .mac_eop(mac_eop), .underflow(underflow), .pkt_count(pkt_count), .ovf_err(ovf_err)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: R7 every read word must match the scoreboard head
  always @(negedge clk) begin
    if (!rst && mac_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R7 unexpected word: actual %0h expected none",
                 {mac_eop, mac_be, mac_data});
      end else begin
        chk("R7 word order", {mac_eop, mac_be, mac_data}, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [31:0] d, input logic eop, input logic [3:0] be, input bit push);
    wr_en = 1'b1; wr_data = d; wr_eop = eop; wr_be = be;
    if (push) exp_q.push_back({eop, be, d});
    @(negedge clk);
    wr_en = 1'b0; wr_eop = 1'b0;
  endtask

  task automatic rd(input int n);
    mac_rd = 1'b1;
    repeat (n) @(negedge clk);
    mac_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    wr_en = 0; wr_eop = 0; wr_data = 0; wr_be = 0; mac_rd = 0; cfg_thresh = 0;
    do_reset();
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 tx_go", tx_go, 0);
    chk("R1 pkt_count", pkt_count, 0);
    chk("R1 ovf_err", ovf_err, 0);
    chk("R1 underflow", underflow, 0);
    chk("R1 mac_valid", mac_valid, 0);

    // packet A, end-of-packet start
    wr(32'hA000_0000, 0, 4'hF, 1);
    wr(32'hA000_0001, 0, 4'hF, 1);
    chk("R6 threshold 0 no start", tx_go, 0);
    rd(1);
    chk("R8 read while idle", mac_valid, 0);
    wr(32'hA000_0002, 1, 4'h3, 1);
    chk("R5 go on end word", tx_go, 1);
    chk("R2 count up", pkt_count, 1);

    // packet B fills the two-packet limit
    wr(32'hB000_0000, 0, 4'hF, 1);
    wr(32'hB000_0001, 1, 4'h1, 1);
    chk("R2 count two", pkt_count, 2);
    chk("R3 ready low at two packets", tx_ready, 0);
    wr(32'hDEAD_BEEF, 0, 4'hF, 0);
    chk("R4 ovf set", ovf_err, 1);

    rd(3);
    chk("R2 count down", pkt_count, 1);
    chk("R9 go kept for next packet", tx_go, 1);
    chk("R3 ready back", tx_ready, 1);
    rd(2);
    chk("R2 count zero", pkt_count, 0);
    chk("R9 go falls", tx_go, 0);
    // R4: the refused word must not precede packet C
    wr(32'hC000_0000, 1, 4'h5, 1);
    rd(1);
    @(negedge clk);
    chk("R4 ovf sticky", ovf_err, 1);
    chk("R4 refused word gone", exp_q.size(), 0);

    // threshold start and underflow
    do_reset();
    cfg_thresh = 9'd4;
    wr(32'h1000_0000, 0, 4'hF, 1);
    wr(32'h1000_0001, 0, 4'hF, 1);
    wr(32'h1000_0002, 0, 4'hF, 1);
    chk("R6 below threshold", tx_go, 0);
    wr(32'h1000_0003, 0, 4'hF, 1);
    chk("R6 threshold start", tx_go, 1);
    rd(4);
    chk("R10 no underflow yet", underflow, 0);
    rd(1);
    chk("R10 underflow pulse", underflow, 1);
    chk("R10 go dropped", tx_go, 0);
    @(negedge clk);
    chk("R10 pulse one cycle", underflow, 0);
    wr(32'h1000_0004, 0, 4'hF, 0);
    wr(32'h1000_0005, 1, 4'hF, 0);
    chk("R10 tail not counted", pkt_count, 0);
    chk("R10 no ovf from drop", ovf_err, 0);
    chk("R10 go stays low", tx_go, 0);
    wr(32'hD000_0000, 0, 4'hF, 1);
    wr(32'hD000_0001, 1, 4'h7, 1);
    chk("R2 next packet counted", pkt_count, 1);
    rd(2);
    @(negedge clk);
    chk("R10 only new packet read", exp_q.size(), 0);

    // word-full limit
    do_reset();
    cfg_thresh = 9'd0;
    for (int i = 0; i < DEPTH - 1; i++) wr(i, 0, 4'hF, 0);
    chk("R3 ready one below full", tx_ready, 1);
    wr(32'hFFFF_FFFF, 0, 4'hF, 0);
    chk("R3 ready low when full", tx_ready, 0);
    chk("R3 no packets", pkt_count, 0);
    wr(32'h0, 0, 4'hF, 0);
    chk("R4 ovf on full", ovf_err, 1);

    chk("R7 scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule